// File: doc/BRIEF.md
# Echoed-clock SPI receive capture

This block latches serial receive data from one or more SDI lanes using a copy of the serial clock that the peripheral side loops back, so that the delay of level shifters or isolators on both the outgoing clock and the returning data drops out of the receive timing. Each lane has its own shift register, clocked by the returned clock on the edge that the built-in clock mode selects. A bit counter in the same domain marks each finished word. Completion crosses into the control clock as a toggle, and the finished lanes are offered there as one parallel word.

The parallel word leaves on a valid/ready stream. `rx_valid` stays high with `rx_data` unchanged until a clock edge sees `rx_ready` high together with it. The serial side cannot be stalled, so a word that completes while the previous one is unread replaces it. The transfer sequencer loads the number of words it expects with `xfer_start`. It reads back `latch_done`, which goes high once that many words have arrived, and `cmd_idle_ok`, which tells it when the transfer command may retire. When the capture parameter is 0, the same shift registers run on the control clock instead, advanced by a sample strobe.

Top module: `echo_rx_capture`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `rx_valid` and `latch_done` are 0 after that edge.
- R2: Each lane shifts most significant bit first. Lane i is presented at `rx_data[i*DATA_WIDTH +: DATA_WIDTH]`.
- R3: With `CLK_MODE` = {CPOL,CPHA} equal to 2'b01 or 2'b10, bits are captured on the falling edge of `echo_clk`. With 2'b00 or 2'b11 they are captured on the rising edge. The mode is a build-time parameter.
- R4: With `ECHO_EN`=1, the word completed by the DATA_WIDTH-th capture edge appears with `rx_valid` high from the third rising `clk` edge after that capture edge. This holds when the capture edge falls between `clk` edges. Each word raises `rx_valid` through exactly one internal one-cycle completion pulse.
- R5: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` stays stable, unless a new word completes. A rising edge with both high clears `rx_valid`, unless a new word completes on that edge.
- R6: A word that completes while `rx_valid` is still high replaces `rx_data`, and `rx_valid` stays high.
- R7: A rising edge with `xfer_start` high loads `xfer_words` as the expected word count, clears the completed-word count and clears `latch_done`.
- R8: `latch_done` goes high on the edge after the completed-word count equals the expected count. It stays high until the next `xfer_start`.
- R9: `cmd_idle_ok` is high exactly when `latch_done` is high, `xfer_busy` is low and `io_pending` is low.
- R10: With `ECHO_EN`=0, `sdi` is captured at rising `clk` edges where `rx_sample` is high, and ignored at other edges. `rx_valid` rises on the edge after the DATA_WIDTH-th sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| echo_clk | input | 1 | Serial clock returned by the peripheral side |
| rx_sample | input | 1 | Control-clock sample strobe, used when ECHO_EN=0 |
| sdi | input | NUM_LANES | Serial receive lanes |
| xfer_start | input | 1 | A new transfer command is accepted |
| xfer_words | input | CNT_W | Number of words the transfer expects |
| xfer_busy | input | 1 | Transfer logic still active |
| io_pending | input | 1 | An IO handshake is outstanding |
| rx_data | output | NUM_LANES*DATA_WIDTH | Captured parallel word |
| rx_valid | output | 1 | rx_data holds an unread word |
| rx_ready | input | 1 | Consumer accepts rx_data |
| latch_done | output | 1 | All expected words have been latched |
| cmd_idle_ok | output | 1 | Transfer command may go idle |

## Verification
The bench drives a rising-edge instance and a falling-edge instance from the same lanes. The data on `sdi` changes between the two clock edges, so each instance must hold its own word, and an instance that captured on the wrong edge would hold the other one. Word pairs are chosen to differ per lane and per bit: 0xA5/0x3C, 0x5A/0xC3, all-ones against all-zeros. These expose swapped lanes and reversed bit order. A second word arriving unread checks the overwrite rule, a continuously high `rx_ready` checks single-cycle acceptance, and `xfer_busy`/`io_pending` combinations separate the three terms of `cmd_idle_ok`. A control-clock instance receives a word with a gap in its sample strobe and garbage on the lanes during the gap, which shows that unsampled cycles leave the word untouched.

// File: rtl/erc_pkg.sv
package erc_pkg;
  // Clock modes {CPOL,CPHA} 01 and 10 capture on the falling edge of the returned clock.
  function automatic logic capture_on_fall(input logic [1:0] mode);
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction
endpackage

// File: rtl/erc_lane_shifter.sv
module erc_lane_shifter #(
  parameter int W = 8
) (
  input  logic         cap_clk,
  input  logic         en_i,
  input  logic         last_i,
  input  logic         sdi_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh;

  // MSB first: earlier bits move toward the top.
  always_ff @(posedge cap_clk) begin
    if (en_i) sh <= {sh[W-2:0], sdi_i};
  end

  // Completed word is frozen so the slow side can read it for a whole word time.
  always_ff @(posedge cap_clk) begin
    if (en_i && last_i) word_o <= {sh[W-2:0], sdi_i};
  end
endmodule

// File: rtl/erc_bit_tracker.sv
module erc_bit_tracker #(
  parameter int W = 8
) (
  input  logic cap_clk,
  input  logic clr_cnt_i,
  input  logic clr_tgl_i,
  input  logic en_i,
  output logic last_o,
  output logic tgl_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  assign last_o = (cnt == LAST);

  always_ff @(posedge cap_clk or posedge clr_cnt_i) begin
    if (clr_cnt_i)  cnt <= '0;
    else if (en_i)  cnt <= last_o ? '0 : cnt + CW'(1);
  end

  // Toggle survives a transfer restart so the far side never sees a false edge.
  always_ff @(posedge cap_clk or posedge clr_tgl_i) begin
    if (clr_tgl_i)            tgl_o <= 1'b0;
    else if (en_i && last_o)  tgl_o <= ~tgl_o;
  end
endmodule

// File: rtl/erc_toggle_sync.sv
module erc_toggle_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [2:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[1:0], tgl_i};
  end

  assign pulse_o = stg[1] ^ stg[2];
endmodule

// File: rtl/erc_xfer_tracker.sv
module erc_xfer_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic [CNT_W-1:0] xfer_words,
  input  logic             word_done,
  output logic             latch_o
);
  logic [CNT_W-1:0] done_cnt;
  logic [CNT_W-1:0] exp_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_cnt <= '0;
      exp_cnt  <= '0;
      latch_o  <= 1'b0;
    end else if (xfer_start) begin
      done_cnt <= '0;
      exp_cnt  <= xfer_words;
      latch_o  <= 1'b0;
    end else begin
      if (word_done)            done_cnt <= done_cnt + CNT_W'(1);
      if (done_cnt == exp_cnt)  latch_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/echo_rx_capture.sv
module echo_rx_capture
  import erc_pkg::*;
#(
  parameter int       DATA_WIDTH = 8,
  parameter int       NUM_LANES  = 2,
  parameter int       CNT_W      = 8,
  parameter bit       ECHO_EN    = 1'b1,
  parameter bit [1:0] CLK_MODE   = 2'b00
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            echo_clk,
  input  logic                            rx_sample,
  input  logic [NUM_LANES-1:0]            sdi,
  input  logic                            xfer_start,
  input  logic [CNT_W-1:0]                xfer_words,
  input  logic                            xfer_busy,
  input  logic                            io_pending,
  output logic [NUM_LANES*DATA_WIDTH-1:0] rx_data,
  output logic                            rx_valid,
  input  logic                            rx_ready,
  output logic                            latch_done,
  output logic                            cmd_idle_ok
);
  localparam int OUT_W = NUM_LANES * DATA_WIDTH;
  localparam bit FALL  = capture_on_fall(CLK_MODE);

  logic             clr_cnt_q;
  logic             clr_tgl_q;
  logic             cap_clk;
  logic             cap_en;
  logic             bit_last;
  logic             word_tgl;
  logic             word_done;
  logic [OUT_W-1:0] hold_bus;

  // Registered clears, glitch-free toward the capture domain.
  always_ff @(posedge clk) begin
    clr_tgl_q <= !rst_n;
    clr_cnt_q <= !rst_n || xfer_start;
  end

  generate
    if (ECHO_EN) begin : g_echo
      if (FALL) begin : g_fall
        assign cap_clk = ~echo_clk;
      end else begin : g_rise
        assign cap_clk = echo_clk;
      end
      assign cap_en = 1'b1;
      erc_toggle_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgl_i   (word_tgl),
        .pulse_o (word_done)
      );
      logic unused_strobe;
      assign unused_strobe = rx_sample;
    end else begin : g_sys
      logic done_q;
      assign cap_clk = clk;
      assign cap_en  = rx_sample;
      always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= rx_sample && bit_last;
      end
      assign word_done = done_q;
      logic unused_echo;
      assign unused_echo = echo_clk ^ word_tgl;
    end
  endgenerate

  erc_bit_tracker #(.W(DATA_WIDTH)) u_trk (
    .cap_clk   (cap_clk),
    .clr_cnt_i (clr_cnt_q),
    .clr_tgl_i (clr_tgl_q),
    .en_i      (cap_en),
    .last_o    (bit_last),
    .tgl_o     (word_tgl)
  );

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      erc_lane_shifter #(.W(DATA_WIDTH)) u_lane (
        .cap_clk (cap_clk),
        .en_i    (cap_en),
        .last_i  (bit_last),
        .sdi_i   (sdi[i]),
        .word_o  (hold_bus[i*DATA_WIDTH +: DATA_WIDTH])
      );
    end
  endgenerate

  // Output stage: a new word always wins over acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (word_done) begin
      rx_valid <= 1'b1;
      rx_data  <= hold_bus;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  erc_xfer_tracker #(.CNT_W(CNT_W)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_words (xfer_words),
    .word_done  (word_done),
    .latch_o    (latch_done)
  );

  assign cmd_idle_ok = latch_done && !xfer_busy && !io_pending;
endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_done,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [OUT_W-1:0] rx_data,
  input logic             xfer_start,
  input logic             latch_done
);
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid); // R5
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !word_done |=> $stable(rx_data)); // R5
  AST_VALID_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(word_done)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !latch_done); // R7
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    latch_done && !xfer_start |=> latch_done); // R8
endmodule

bind echo_rx_capture erc_checker #(.OUT_W(NUM_LANES*DATA_WIDTH)) i_erc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_done  (word_done),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .xfer_start (xfer_start),
  .latch_done (latch_done)
);

// File: tb/test_echo_rx_capture.sv
module test_echo_rx_capture;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic echo_clk = 1'b0;
  logic [1:0] sdi = 2'b00;
  logic xfer_start = 1'b0;
  logic [7:0] xfer_words = 8'd0;
  logic xfer_busy = 1'b0;
  logic io_pending = 1'b0;
  logic rx_ready = 1'b0;
  logic sys_sample = 1'b0;
  logic [1:0] sys_sdi = 2'b00;

  logic [15:0] p_data, n_data, s_data;
  logic p_valid, n_valid, s_valid;
  logic p_latch, n_latch, s_latch;
  logic p_idle, n_idle, s_idle;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  echo_rx_capture #(.CLK_MODE(2'b00)) i_echo_rx_capture (
    .clk(clk), .rst_n(rst_n), .echo_clk(echo_clk), .rx_sample(1'b0), .sdi(sdi),
    .xfer_start(xfer_start), .xfer_words(xfer_words), .xfer_busy(xfer_busy),
    .io_pending(io_pending), .rx_data(p_data), .rx_valid(p_valid), .rx_ready(rx_ready),
    .latch_done(p_latch), .cmd_idle_ok(p_idle));

  echo_rx_capture #(.CLK_MODE(2'b01)) i_echo_rx_capture_neg (
    .clk(clk), .rst_n(rst_n), .echo_clk(echo_clk), .rx_sample(1'b0), .sdi(sdi),
    .xfer_start(xfer_start), .xfer_words(xfer_words), .xfer_busy(xfer_busy),
    .io_pending(io_pending), .rx_data(n_data), .rx_valid(n_valid), .rx_ready(rx_ready),
    .latch_done(n_latch), .cmd_idle_ok(n_idle));

  echo_rx_capture #(.ECHO_EN(1'b0)) i_echo_rx_capture_sys (
    .clk(clk), .rst_n(rst_n), .echo_clk(1'b0), .rx_sample(sys_sample), .sdi(sys_sdi),
    .xfer_start(xfer_start), .xfer_words(xfer_words), .xfer_busy(xfer_busy),
    .io_pending(io_pending), .rx_data(s_data), .rx_valid(s_valid), .rx_ready(1'b0),
    .latch_done(s_latch), .cmd_idle_ok(s_idle));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Reference model, index 0 = rising-edge instance, 1 = falling-edge instance.
  bit          evt [2];
  logic [15:0] evw [2];
  int          age [2];
  logic [15:0] pw  [2];
  bit          mv  [2];
  logic [15:0] md  [2];
  int          mcnt[2];
  int          mexp[2];
  bit          ml  [2];

  initial begin
    for (int k = 0; k < 2; k++) begin
      evt[k] = 0; age[k] = 0; mv[k] = 0; mcnt[k] = 0; mexp[k] = 0; ml[k] = 0;
      evw[k] = '0; pw[k] = '0; md[k] = '0;
    end
  end

  always @(negedge clk) begin
    bit dlv;
    for (int k = 0; k < 2; k++) begin
      dlv = 0;
      if (age[k] > 0) begin
        age[k]++;
        if (age[k] == 3) begin dlv = 1; age[k] = 0; end
      end
      if (evt[k]) begin age[k] = 1; pw[k] = evw[k]; evt[k] = 0; end
      if (!rst_n) begin
        mv[k] = 0; mcnt[k] = 0; mexp[k] = 0; ml[k] = 0;
      end else begin
        if (xfer_start) begin
          mcnt[k] = 0; mexp[k] = int'(xfer_words); ml[k] = 0;
        end else begin
          if (mcnt[k] == mexp[k]) ml[k] = 1;
          if (dlv) mcnt[k] = (mcnt[k] + 1) % 256;
        end
        if (dlv) begin mv[k] = 1; md[k] = pw[k]; end
        else if (mv[k] && rx_ready) mv[k] = 0;
      end
      chk("R4 rx_valid", (k == 0) ? 32'(p_valid) : 32'(n_valid), 32'(mv[k]));
      if (mv[k]) chk((k == 0) ? "R2 rx_data" : "R3 rx_data",
                     (k == 0) ? 32'(p_data) : 32'(n_data), 32'(md[k]));
      chk("R8 latch_done", (k == 0) ? 32'(p_latch) : 32'(n_latch), 32'(ml[k]));
      chk("R9 cmd_idle_ok", (k == 0) ? 32'(p_idle) : 32'(n_idle),
          32'(ml[k] && !xfer_busy && !io_pending));
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive a bit pair per edge: rising edge takes pa/pb, falling edge takes na/nb.
  task automatic send_pair(input logic [7:0] pa, input logic [7:0] pb,
                           input logic [7:0] na, input logic [7:0] nb);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk); #1 sdi = {pb[b], pa[b]};
      @(negedge clk); #1 echo_clk = 1'b1;
      if (b == 0) begin evw[0] = {pb, pa}; evt[0] = 1; end
      @(negedge clk); #1 sdi = {nb[b], na[b]};
      @(negedge clk); #1 echo_clk = 1'b0;
      if (b == 0) begin evw[1] = {nb, na}; evt[1] = 1; end
    end
  endtask

  task automatic start_xfer(input logic [7:0] n);
    @(negedge clk); #1 xfer_start = 1'b1; xfer_words = n;
    @(negedge clk); #1 xfer_start = 1'b0;
  endtask

  initial begin
    cycles(4);
    chk("R1 rx_valid after reset", 32'(p_valid), 32'd0);
    chk("R1 latch_done after reset", 32'(p_latch), 32'd0);
    #1 rst_n = 1'b1;

    start_xfer(8'd2);
    @(negedge clk);
    chk("R7 latch_done cleared by start", 32'(p_latch), 32'd0);
    cycles(2);
    send_pair(8'hA5, 8'h3C, 8'h5A, 8'hC3);
    cycles(6);
    chk("R2 lane packing", 32'(p_data), 32'h3CA5);
    chk("R3 falling-edge word", 32'(n_data), 32'hC35A);
    chk("R8 one of two words", 32'(p_latch), 32'd0);

    send_pair(8'h81, 8'h7E, 8'h18, 8'hE7);
    cycles(6);
    chk("R6 overwrite valid", 32'(p_valid), 32'd1);
    chk("R6 overwrite data", 32'(p_data), 32'h7E81);
    chk("R8 latch after two words", 32'(p_latch), 32'd1);

    #1 xfer_busy = 1'b1;
    @(negedge clk);
    chk("R9 busy blocks idle", 32'(p_idle), 32'd0);
    #1 xfer_busy = 1'b0; io_pending = 1'b1;
    @(negedge clk);
    chk("R9 io pending blocks idle", 32'(p_idle), 32'd0);
    #1 io_pending = 1'b0;
    @(negedge clk);
    chk("R9 idle allowed", 32'(p_idle), 32'd1);

    #1 rx_ready = 1'b1;
    @(negedge clk); #1 rx_ready = 1'b0;
    @(negedge clk);
    chk("R5 accepted word clears valid", 32'(p_valid), 32'd0);

    start_xfer(8'd1);
    @(negedge clk);
    chk("R7 restart clears latch", 32'(p_latch), 32'd0);
    #1 rx_ready = 1'b1;
    cycles(2);
    send_pair(8'hFF, 8'h00, 8'h00, 8'hFF);
    cycles(6);
    chk("R5 ready held: valid drops", 32'(p_valid), 32'd0);
    chk("R8 single word latch", 32'(n_latch), 32'd1);
    #1 rx_ready = 1'b0;

    // Control-clock capture with a strobe gap carrying garbage.
    for (int bt = 7; bt >= 0; bt--) begin
      logic [7:0] a = 8'h96;
      logic [7:0] b = 8'h0F;
      @(negedge clk); #1 sys_sample = 1'b1; sys_sdi = {b[bt], a[bt]};
      if (bt == 4) begin @(negedge clk); #1 sys_sample = 1'b0; sys_sdi = 2'b01; end
    end
    @(negedge clk);
    chk("R10 valid not before next edge", 32'(s_valid), 32'd0);
    #1 sys_sample = 1'b0;
    @(negedge clk);
    chk("R10 valid after last sample", 32'(s_valid), 32'd1);
    chk("R10 data ignores unsampled cycle", 32'(s_data), 32'h0F96);

    cycles(4);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule